// File: doc/BRIEF.md
# Firmware Hub Single-Byte Write Target

This block is the device end of a 4-bit multiplexed firmware memory bus. It watches an active-low frame strobe and the shared nibble bus, and recognises a write request by its start nibble. It then checks a device-select nibble against a strap input and shifts in a 28-bit address, a size nibble and one data byte. After that it takes the bus for a fixed five-clock epilogue: a turnaround, a one-clock ready code, and a second turnaround that hands the bus back to the host.

On the local side the block presents a one-clock write strobe with the assembled address and byte. Two host mistakes are never reported on the bus: a size other than one byte, and an address at or above a configurable limit. For either of these the write is dropped and a sticky internal error flag is set, while the bus epilogue still ends in the ready code. The bidirectional bus is split into an input, a driven value and an output enable.

Top module: `fwh_wr_target`

## Requirements
- R1: A cycle starts only at a clock in which `frame_n` is 0 and `ad_i` is 4'b1111. A low frame with any other nibble starts nothing: the block does not drive the bus and does not write.
- R2: The nibble in the first clock after the start is the device select. If it differs from `strap_id`, the block keeps `ad_oe` at 0 and `mem_we` at 0 until the next start.
- R3: After the select nibble come seven address nibbles, most significant first, then a size nibble, then the data low nibble, then the data high nibble. `mem_addr` and `mem_data` carry the assembled values.
- R4: For an accepted write, `mem_we` is 1 for exactly one clock. That clock is the first clock after the data high nibble.
- R5: The epilogue starts in the clock after the data high nibble and has five clocks. In order, the block drives 4'b1111, releases the bus, drives 4'b0000, drives 4'b1111 and releases the bus. It then returns to idle with `ad_oe` at 0.
- R6: A size nibble other than 0 suppresses the write and sets `err_flag`. The epilogue is the same as in R5.
- R7: An address at or above `ADDR_LIMIT` suppresses the write and sets `err_flag`. The epilogue is the same as in R5. The address `ADDR_LIMIT-1` is accepted.
- R8: `err_flag` stays 1 until reset. While `ad_oe` is 1, `ad_o` is always 4'b1111 or 4'b0000, so no error or wait code ever reaches the bus.
- R9: If `frame_n` goes to 0 during any non-idle clock, the current cycle is abandoned: the block stops driving and does not write. If that nibble is 4'b1111, a new cycle begins.
- R10: After reset, `ad_oe`, `mem_we` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle frame from the host |
| ad_i | input | 4 | Nibble sampled from the shared bus |
| ad_o | output | 4 | Nibble driven onto the shared bus |
| ad_oe | output | 1 | Bus drive enable |
| strap_id | input | 4 | Device select value this target answers to |
| mem_we | output | 1 | One-clock local write strobe |
| mem_addr | output | 28 | Local write address |
| mem_data | output | 8 | Local write byte |
| err_flag | output | 1 | Sticky flag for a bad size or an out-of-range address |

## Verification
Every result shows up one clock after the nibble that causes it. The strobe, the address, the byte and the error flag appear in the clock after the data high nibble. Each epilogue code appears one clock later than the one before it, and idle follows in the sixth clock. An abort takes effect in the clock after the frame is pulled low. The bench drives on the falling edge and samples on the next falling edge, so each sample sees exactly the registers updated by the rising edge between them. It counts these clocks explicitly and checks every expected value at that point.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    localparam logic [3:0] START_WR  = 4'b1111;
    localparam logic [3:0] CODE_RDY  = 4'b0000;
    localparam logic [3:0] CODE_TURN = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR,
        ST_SIZE,
        ST_DLO,
        ST_DHI,
        ST_TA1_DRV,
        ST_TA1_REL,
        ST_SYNC,
        ST_TA2_DRV,
        ST_TA2_REL
    } fwh_state_e;

    typedef struct packed {
        logic cap_addr;
        logic cap_size;
        logic cap_dlo;
        logic cap_dhi;
    } fwh_cap_t;

endpackage

// File: rtl/fwh_cyc_fsm.sv
module fwh_cyc_fsm
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [3:0] ad_i,
    input  logic [3:0] strap_id,
    output fwh_state_e state,
    output fwh_cap_t   cap
);
    localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

    typedef struct packed {
        fwh_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;
    fwh_cap_t  cap_d;

    always_comb begin
        r_d   = r_q;
        cap_d = '0;
        if (!frame_n && r_q.st != ST_IDLE) begin
            r_d.st  = (ad_i == START_WR) ? ST_DEVSEL : ST_IDLE;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!frame_n && ad_i == START_WR) r_d.st = ST_DEVSEL;
                end
                ST_DEVSEL: begin
                    r_d.cnt = '0;
                    r_d.st  = (ad_i == strap_id) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    cap_d.cap_addr = 1'b1;
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.st  = ST_SIZE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_SIZE: begin
                    cap_d.cap_size = 1'b1;
                    r_d.st         = ST_DLO;
                end
                ST_DLO: begin
                    cap_d.cap_dlo = 1'b1;
                    r_d.st        = ST_DHI;
                end
                ST_DHI: begin
                    cap_d.cap_dhi = 1'b1;
                    r_d.st        = ST_TA1_DRV;
                end
                ST_TA1_DRV: r_d.st = ST_TA1_REL;
                ST_TA1_REL: r_d.st = ST_SYNC;
                ST_SYNC:    r_d.st = ST_TA2_DRV;
                ST_TA2_DRV: r_d.st = ST_TA2_REL;
                ST_TA2_REL: r_d.st = ST_IDLE;
                default:    r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
    assign cap   = cap_d;

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && !frame_n && ad_i != START_WR) |=> r_q.st == ST_IDLE); // R9
    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && !frame_n && ad_i == START_WR) |=> r_q.st == ST_DEVSEL); // R9
    AST_EPI_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TA1_DRV && frame_n) |=> r_q.st == ST_TA1_REL); // R5
    AST_EPI_END: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TA2_REL && frame_n) |=> r_q.st == ST_IDLE); // R5
    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cap_d) <= 1); // R3
endmodule

// File: rtl/fwh_collect.sv
module fwh_collect
    import fwh_pkg::*;
#(
    parameter int          ADDR_W     = 28,
    parameter int          DATA_W     = 8,
    parameter logic [27:0] ADDR_LIMIT = 28'h8000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ad_i,
    input  fwh_cap_t          cap,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              bad
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [3:0]        size;
        logic [DATA_W-1:0] data;
    } col_regs_t;

    col_regs_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (cap.cap_addr) c_d.addr = {c_q.addr[ADDR_W-5:0], ad_i};
        if (cap.cap_size) c_d.size = ad_i;
        if (cap.cap_dlo)  c_d.data[HALF_W-1:0] = ad_i[HALF_W-1:0];
        if (cap.cap_dhi)  c_d.data[DATA_W-1:HALF_W] = ad_i[HALF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign addr = c_q.addr;
    assign data = c_q.data;
    assign bad  = (c_q.size != 4'd0) || (c_q.addr >= ADDR_W'(ADDR_LIMIT));

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap.cap_size || cap.cap_dlo || cap.cap_dhi) |=> $stable(c_q.addr)); // R3
endmodule

// File: rtl/fwh_commit.sv
module fwh_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic bad,
    output logic we,
    output logic err
);
    typedef struct packed {
        logic we;
        logic err;
    } cmt_regs_t;

    cmt_regs_t m_q, m_d;

    always_comb begin
        m_d    = m_q;
        m_d.we = fire && !bad;
        if (fire && bad) m_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign we  = m_q.we;
    assign err = m_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.err |=> m_q.err); // R8
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.we |=> !m_q.we); // R4
endmodule

// File: rtl/fwh_wr_target.sv
module fwh_wr_target
    import fwh_pkg::*;
#(
    parameter int          ADDR_W     = 28,
    parameter int          DATA_W     = 8,
    parameter logic [27:0] ADDR_LIMIT = 28'h8000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        ad_i,
    output logic [3:0]        ad_o,
    output logic              ad_oe,
    input  logic [3:0]        strap_id,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              err_flag
);
    localparam int ADDR_NIBS = ADDR_W / 4;

    fwh_state_e state;
    fwh_cap_t   cap;
    logic       bad;

    fwh_cyc_fsm #(.ADDR_NIBS(ADDR_NIBS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .ad_i     (ad_i),
        .strap_id (strap_id),
        .state    (state),
        .cap      (cap)
    );

    fwh_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_LIMIT(ADDR_LIMIT)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .ad_i  (ad_i),
        .cap   (cap),
        .addr  (mem_addr),
        .data  (mem_data),
        .bad   (bad)
    );

    fwh_commit u_cmt (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (cap.cap_dhi),
        .bad   (bad),
        .we    (mem_we),
        .err   (err_flag)
    );

    always_comb begin
        ad_oe = 1'b0;
        ad_o  = CODE_TURN;
        unique case (state)
            ST_TA1_DRV, ST_TA2_DRV: ad_oe = 1'b1;
            ST_SYNC: begin
                ad_oe = 1'b1;
                ad_o  = CODE_RDY;
            end
            default: ad_oe = 1'b0;
        endcase
    end

    AST_WE_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ad_oe && ad_o == CODE_TURN)); // R4
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !mem_we); // R6
    AST_BUS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (ad_o == CODE_TURN || ad_o == CODE_RDY)); // R8
    AST_SYNC_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && ad_o == CODE_RDY) |-> !$past(ad_oe)); // R5
endmodule

// File: tb/fwh_wr_target_tb_top.sv
module fwh_wr_target_tb_top;
    localparam logic [27:0] LIM   = 28'h8000000;
    localparam logic [3:0]  STRAP = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  ad_i = 4'h0;
    logic [3:0]  ad_o;
    logic        ad_oe;
    logic        mem_we;
    logic [27:0] mem_addr;
    logic [7:0]  mem_data;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;
    bit err_m  = 1'b0;

    always #5 clk = ~clk;

    fwh_wr_target #(.ADDR_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad_i(ad_i),
        .ad_o(ad_o), .ad_oe(ad_oe), .strap_id(STRAP), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [27:0] a, input logic [3:0] sz);
        return (sz != 4'd0) || (a >= LIM);
    endfunction

    // Drives the first n nibbles of a write (start included); returns after the last one is consumed.
    task automatic preamble(input logic [3:0] dev, input logic [27:0] a, input logic [3:0] sz,
                            input logic [7:0] d, input int n);
        logic [3:0] nib [12];
        nib[0] = 4'hF; nib[1] = dev;
        for (int k = 0; k < 7; k++) nib[2+k] = a[27-4*k -: 4];
        nib[9] = sz; nib[10] = d[3:0]; nib[11] = d[7:4];
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                chk(!ad_oe && !mem_we, "R3 quiet during preamble", {ad_oe, mem_we}, 0);
            end
            frame_n = (i == 0) ? 1'b0 : 1'b1;
            ad_i    = nib[i];
            @(negedge clk);
        end
        frame_n = 1'b1;
        ad_i    = 4'h0;
    endtask

    task automatic write_cyc(input logic [3:0] dev, input logic [27:0] a, input logic [3:0] sz,
                             input logic [7:0] d, input bit epi_abort);
        bit hit = (dev == STRAP);
        bit bd  = is_bad(a, sz);
        bit oe_e  [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
        logic [3:0] v_e [6] = '{4'hF, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0};
        preamble(dev, a, sz, d, 12);
        if (!hit) begin
            for (int i = 0; i < 6; i++) begin
                chk(!ad_oe && !mem_we, "R2 unselected stays off bus", {ad_oe, mem_we}, 0);
                @(negedge clk);
            end
            return;
        end
        if (bd) err_m = 1'b1;
        chk(mem_we == !bd, bd ? "R6/R7 write suppressed" : "R4 strobe", mem_we, !bd);
        chk(err_flag == err_m, "R8 err flag", err_flag, err_m);
        if (!bd) begin
            chk(mem_addr == a, "R3 address", mem_addr, a);
            chk(mem_data == d, "R3 data", mem_data, d);
        end
        if (epi_abort) begin
            frame_n = 1'b0; ad_i = 4'h0;
            @(negedge clk);
            frame_n = 1'b1;
            for (int i = 0; i < 3; i++) begin
                chk(!ad_oe && !mem_we, "R9 abort in epilogue", {ad_oe, mem_we}, 0);
                @(negedge clk);
            end
            return;
        end
        for (int i = 0; i < 6; i++) begin
            chk(ad_oe == oe_e[i], "R5 epilogue enable", ad_oe, oe_e[i]);
            if (oe_e[i]) chk(ad_o == v_e[i], "R5 epilogue code", ad_o, v_e[i]);
            if (i > 0) chk(!mem_we, "R4 single strobe", mem_we, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!ad_oe && !mem_we && !err_flag, "R10 reset state", {ad_oe, mem_we, err_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ad_oe && !mem_we && !err_flag, "R10 after release", {ad_oe, mem_we, err_flag}, 0);

        // R1: wrong start nibble
        frame_n = 1'b0; ad_i = 4'h0;
        @(negedge clk);
        frame_n = 1'b1; ad_i = STRAP;
        for (int i = 0; i < 14; i++) begin
            chk(!ad_oe && !mem_we, "R1 no start", {ad_oe, mem_we}, 0);
            @(negedge clk);
        end

        write_cyc(STRAP, 28'h1234567, 4'h0, 8'hA5, 1'b0);
        write_cyc(STRAP, LIM - 28'd1, 4'h0, 8'h3C, 1'b0);   // R7 boundary accepted
        write_cyc(4'hA, 28'h0000010, 4'h0, 8'h11, 1'b0);    // R2
        // R9: abort mid-address with a fresh start nibble, then complete
        preamble(STRAP, 28'h0ABCDEF, 4'h0, 8'h77, 5);
        write_cyc(STRAP, 28'h0000FFF, 4'h0, 8'h5A, 1'b0);
        // R9: abort with non-start nibble
        preamble(STRAP, 28'h0000001, 4'h0, 8'h01, 11);
        frame_n = 1'b0; ad_i = 4'h3;
        @(negedge clk);
        frame_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            chk(!ad_oe && !mem_we, "R9 abort to idle", {ad_oe, mem_we}, 0);
            @(negedge clk);
        end
        write_cyc(STRAP, 28'h0000123, 4'h0, 8'hC3, 1'b1);   // R9 epilogue abort
        write_cyc(STRAP, 28'h0000040, 4'h2, 8'h99, 1'b0);   // R6
        write_cyc(STRAP, LIM, 4'h0, 8'h42, 1'b0);           // R7
        write_cyc(STRAP, 28'h0000050, 4'h0, 8'h24, 1'b0);   // R8 flag stays

        rst_n = 1'b0; err_m = 1'b0;
        @(negedge clk);
        chk(!err_flag, "R10 err cleared by reset", err_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < 80; n++) begin
            logic [31:0] r = $urandom;
            logic [3:0]  dv = (r[2:0] == 3'd0) ? 4'(r[7:4]) : STRAP;
            logic [3:0]  sz = (r[12:9] == 4'd0) ? 4'(r[15:13]) : 4'h0;
            logic [27:0] a  = 28'($urandom);
            logic [7:0]  d  = 8'($urandom);
            write_cyc(dv, a, sz, d, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule